// File: doc/BRIEF.md
# Overcurrent Fault Response Controller

This block supervises the four switches of an H-bridge power stage. Each switch reports its own overcurrent flag. The block filters these flags against a deglitch interval, so a brief spike does not trip it. Once a flag has stayed high for the full interval, the block shuts the bridge down. It forces every gate enable low, sets two sticky status bits and pulls an active-low fault pin.

A mode input picks what happens next. In latching mode the bridge stays off until a clear-fault pulse arrives or the block is reset. The reset stands for a supply power cycle. In retry mode the bridge stays off for a fixed wait time and is then re-armed from the live control inputs. If the overcurrent is still there, the block trips again after another deglitch interval, and this repeats until the fault goes away. Detection uses only the four flags and does not depend on any current-regulation or reference setting.

Top module: `ocp_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, the block leaves that edge in the normal state: `fault_n`=1, `fault_st`=0, `ocp_st`=0, and `bridge_en` equal to `bridge_in`. This applies whatever state the block was in before.
- R2: A fault trips on the clock edge at which the OR of `oc_flag` has been sampled high on DEGLITCH_CYC consecutive edges. Any single flag bit can trip it. Bit 0 is high-side A, bit 1 is low-side A, bit 2 is high-side B and bit 3 is low-side B.
- R3: If all flags are sampled low at any edge before the count completes, the count starts again from zero. In that case no fault trips.
- R4: From the trip edge onward, `bridge_en` is 0 on all bits, `fault_n` is 0, and both `fault_st` and `ocp_st` are 1.
- R5: `retry_mode` is sampled at the trip edge. A value of 1 selects timed retry and 0 selects latched shutdown.
- R6: In retry, the bridge stays disabled and `fault_n` stays low for exactly RETRY_CYC clock cycles after the trip edge. After that, `fault_n` returns to 1 and `bridge_en` follows the live `bridge_in`.
- R7: If an overcurrent flag is still high when the bridge is re-armed after a retry, the block trips again DEGLITCH_CYC edges later and enters a new retry wait.
- R8: In latched shutdown, the bridge stays disabled and `fault_n` stays low for as long as no `clr_fault` is seen.
- R9: A `clr_fault` sampled during latched shutdown returns the block to normal operation at that edge and clears both status bits.
- R10: After a successful retry, `fault_st` and `ocp_st` stay at 1. A `clr_fault` sampled in normal operation clears both of them.
- R11: A `clr_fault` sampled during a retry wait has no effect. The wait length is unchanged and the status bits stay set.
- R12: In normal operation, `bridge_en` equals `bridge_in` bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| oc_flag | input | 4 | Per-switch overcurrent flags: HS-A, LS-A, HS-B, LS-B (bit 0 to bit 3) |
| retry_mode | input | 1 | 1 = timed retry, 0 = latched shutdown |
| clr_fault | input | 1 | Clear-fault pulse |
| bridge_in | input | 4 | Requested gate enables, same bit order as `oc_flag` |
| bridge_en | output | 4 | Gated gate enables to the power stage |
| fault_st | output | 1 | Sticky fault status bit |
| ocp_st | output | 1 | Sticky overcurrent status bit |
| fault_n | output | 1 | Active-low fault pin |

## Verification
The assertions check the following on every cycle:
- The deglitch count falls to zero whenever all flags are low.
- The retry counter stays inside its window.
- A trip lands in a disabled state with both status bits set.
- A latched shutdown holds until a clear pulse arrives.
- A retry exit keeps the status bits.
- The enables pass straight through while the fault pin is high.

Several behaviours depend on exact cycle counts and event order, so only the bench's directed scenarios can show them. These are:
- the precise edge on which a trip lands, one edge after the near miss;
- the exact length of the retry wait;
- a second trip when the overcurrent persists;
- the count restarting after a one-cycle gap;
- each single flag bit tripping on its own;
- a clear pulse being ignored during a retry wait.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_RETRY   = 2'd1,
        ST_LATCHED = 2'd2
    } ocp_state_e;

    typedef struct packed {
        logic fault;
        logic ocp;
    } ocp_status_t;

    localparam ocp_status_t STATUS_CLEAR = '{fault: 1'b0, ocp: 1'b0};
    localparam ocp_status_t STATUS_TRIP  = '{fault: 1'b1, ocp: 1'b1};

    function automatic logic gate_open(input ocp_state_e st);
        return st == ST_RUN;
    endfunction

endpackage

// File: rtl/ocp_deglitch.sv
module ocp_deglitch #(
    parameter int NUM_SW       = 4,
    parameter int DEGLITCH_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [NUM_SW-1:0] oc_vec,
    output logic              trip
);
    localparam int CW = $clog2(DEGLITCH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEGLITCH_CYC - 1);

    logic          any_oc;
    logic [CW-1:0] cnt;

    assign any_oc = |oc_vec;
    assign trip   = arm && any_oc && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !arm || !any_oc) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: a cycle with no flag high restarts the filter
    a_r3_count_restart: assert property (@(posedge clk) disable iff (rst)
        !any_oc |=> cnt == '0);

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer #(
    parameter int RETRY_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int TW = $clog2(RETRY_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(RETRY_CYC - 1);

    logic [TW-1:0] tcnt;

    assign done = run && (tcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // R6: wait counter never exceeds the programmed window
    a_r6_timer_bounded: assert property (@(posedge clk) disable iff (rst)
        tcnt <= LAST);

endmodule

// File: rtl/ocp_fault_fsm.sv
module ocp_fault_fsm
    import ocp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trip,
    input  logic        retry_mode,
    input  logic        clr_fault,
    input  logic        retry_done,
    output ocp_state_e  state,
    output ocp_status_t status
);
    ocp_state_e  state_nx;
    ocp_status_t status_nx;

    always_comb begin
        state_nx  = state;
        status_nx = status;
        unique case (state)
            ST_RUN: begin
                if (trip) begin
                    state_nx  = retry_mode ? ST_RETRY : ST_LATCHED;
                    status_nx = STATUS_TRIP;
                end else if (clr_fault) begin
                    status_nx = STATUS_CLEAR;
                end
            end
            ST_RETRY: begin
                if (retry_done) begin
                    state_nx = ST_RUN;
                end
            end
            ST_LATCHED: begin
                if (clr_fault) begin
                    state_nx  = ST_RUN;
                    status_nx = STATUS_CLEAR;
                end
            end
            default: begin
                state_nx = ST_LATCHED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RUN;
            status <= STATUS_CLEAR;
        end else begin
            state  <= state_nx;
            status <= status_nx;
        end
    end

    // R4: a trip leaves the run state with both status bits raised
    a_r4_trip_sets_status: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && trip) |=> (state != ST_RUN && status.ocp && status.fault));

    // R8: latched shutdown holds without a clear pulse
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCHED && !clr_fault) |=> state == ST_LATCHED);

    // R9: clear pulse in latched shutdown resumes operation with status cleared
    a_r9_clear_releases: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCHED && clr_fault) |=> (state == ST_RUN && !status.ocp && !status.fault));

    // R10: a retry exit keeps the sticky status
    a_r10_retry_keeps_status: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RETRY && retry_done) |=> (state == ST_RUN && status.ocp && status.fault));

    // R11: clear pulse during a retry wait changes nothing
    a_r11_clear_ignored_in_retry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RETRY && !retry_done) |=> (state == ST_RETRY && status.ocp));

endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor
    import ocp_pkg::*;
#(
    parameter int NUM_SW       = 4,
    parameter int DEGLITCH_CYC = 8,
    parameter int RETRY_CYC    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SW-1:0] oc_flag,
    input  logic              retry_mode,
    input  logic              clr_fault,
    input  logic [NUM_SW-1:0] bridge_in,
    output logic [NUM_SW-1:0] bridge_en,
    output logic              fault_st,
    output logic              ocp_st,
    output logic              fault_n
);
    ocp_state_e  state;
    ocp_status_t status;
    logic        trip;
    logic        retry_done;
    logic        open_gate;

    ocp_deglitch #(
        .NUM_SW       (NUM_SW),
        .DEGLITCH_CYC (DEGLITCH_CYC)
    ) u_deglitch (
        .clk    (clk),
        .rst    (rst),
        .arm    (open_gate),
        .oc_vec (oc_flag),
        .trip   (trip)
    );

    ocp_retry_timer #(
        .RETRY_CYC (RETRY_CYC)
    ) u_retry (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_RETRY),
        .done (retry_done)
    );

    ocp_fault_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .trip       (trip),
        .retry_mode (retry_mode),
        .clr_fault  (clr_fault),
        .retry_done (retry_done),
        .state      (state),
        .status     (status)
    );

    assign open_gate = gate_open(state);

    for (genvar i = 0; i < NUM_SW; i++) begin : g_gate
        assign bridge_en[i] = open_gate & bridge_in[i];
    end

    assign fault_n  = open_gate;
    assign fault_st = status.fault;
    assign ocp_st   = status.ocp;

    // R12: enables follow the requests while no fault is shown
    a_r12_passthrough: assert property (@(posedge clk) disable iff (rst)
        fault_n |-> bridge_en == bridge_in);

    // R4: a shown fault never lets a gate through
    a_r4_gates_off: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> bridge_en == '0);

endmodule

// File: tb/ocp_supervisor_tb.sv
module ocp_supervisor_tb;
    localparam int N   = 4;
    localparam int DEG = 8;
    localparam int RET = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] oc_flag = '0;
    logic         retry_mode = 1'b1;
    logic         clr_fault = 1'b0;
    logic [N-1:0] bridge_in = 4'b1001;
    logic [N-1:0] bridge_en;
    logic         fault_st, ocp_st, fault_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ocp_supervisor #(.NUM_SW(N), .DEGLITCH_CYC(DEG), .RETRY_CYC(RET)) u_dut (
        .clk(clk), .rst(rst), .oc_flag(oc_flag), .retry_mode(retry_mode),
        .clr_fault(clr_fault), .bridge_in(bridge_in), .bridge_en(bridge_en),
        .fault_st(fault_st), .ocp_st(ocp_st), .fault_n(fault_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // packed view of outputs: {fault_n, fault_st, ocp_st, bridge_en}
    function automatic int obs();
        return {fault_n, fault_st, ocp_st, bridge_en};
    endfunction

    function automatic int normal(input logic [N-1:0] req, input logic st);
        return {1'b1, st, st, req};
    endfunction

    localparam int TRIPPED = {1'b0, 1'b1, 1'b1, 4'b0000};

    task automatic do_reset();
        rst = 1'b1; oc_flag = '0; clr_fault = 1'b0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk(obs() == normal(bridge_in, 1'b0), "R1 reset state", obs(), normal(bridge_in, 1'b0));
        bridge_in = 4'b0110; step(1);
        chk(obs() == normal(4'b0110, 1'b0), "R12 passthrough", obs(), normal(4'b0110, 1'b0));
    endtask

    task automatic trip_bit(input int b, input bit mode);
        retry_mode = mode;
        oc_flag = N'(1) << b;
        step(DEG - 1);
        chk(fault_n == 1'b1, "R2 no trip one edge early", fault_n, 1);
        step(1);
        chk(obs() == TRIPPED, "R4 tripped outputs", obs(), TRIPPED);
    endtask

    task automatic t_each_bit();
        for (int b = 0; b < N; b++) begin
            do_reset();
            bridge_in = 4'b1111;
            trip_bit(b, 1'b0);
            chk(fault_n == 1'b0, "R2 single flag bit trips", b, b);
        end
    endtask

    task automatic t_gap();
        do_reset();
        bridge_in = 4'b0101;
        oc_flag = 4'b0010; step(DEG - 1);
        oc_flag = 4'b0000; step(1);
        oc_flag = 4'b1000; step(DEG - 1);
        chk(obs() == normal(4'b0101, 1'b0), "R3 gap restarts count", obs(), normal(4'b0101, 1'b0));
        step(1);
        chk(fault_n == 1'b0, "R3 trip after full run", fault_n, 0);
    endtask

    task automatic t_retry();
        do_reset();
        bridge_in = 4'b1001;
        trip_bit(0, 1'b1);
        oc_flag = '0;
        retry_mode = 1'b0; // changes after trip must not matter (R5)
        step(3);
        clr_fault = 1'b1; step(1); clr_fault = 1'b0;
        chk(obs() == TRIPPED, "R11 clear ignored in retry", obs(), TRIPPED);
        step(RET - 5);
        chk(fault_n == 1'b0, "R6 still waiting one cycle before end", fault_n, 0);
        step(1);
        chk(obs() == normal(4'b1001, 1'b1), "R6/R10 re-armed with status kept", obs(), normal(4'b1001, 1'b1));
        bridge_in = 4'b0110; step(1);
        chk(bridge_en == 4'b0110, "R6 follows live inputs", bridge_en, 4'b0110);
        clr_fault = 1'b1; step(1); clr_fault = 1'b0;
        chk(obs() == normal(4'b0110, 1'b0), "R10 clear in run clears status", obs(), normal(4'b0110, 1'b0));
    endtask

    task automatic t_persist();
        do_reset();
        bridge_in = 4'b1010;
        trip_bit(2, 1'b1);
        step(RET);
        chk(fault_n == 1'b1, "R7 re-armed after wait", fault_n, 1);
        step(DEG - 1);
        chk(fault_n == 1'b1, "R7 no early re-trip", fault_n, 1);
        step(1);
        chk(obs() == TRIPPED, "R7 second trip", obs(), TRIPPED);
        step(RET);
        chk(fault_n == 1'b1, "R7 second wait same length", fault_n, 1);
        oc_flag = '0;
    endtask

    task automatic t_latch();
        do_reset();
        bridge_in = 4'b0011;
        trip_bit(1, 1'b0);
        oc_flag = '0;
        step(RET + 10);
        chk(obs() == TRIPPED, "R8 latched holds", obs(), TRIPPED);
        clr_fault = 1'b1; step(1); clr_fault = 1'b0;
        chk(obs() == normal(4'b0011, 1'b0), "R9 clear releases latch", obs(), normal(4'b0011, 1'b0));
        trip_bit(3, 1'b0);
        rst = 1'b1; step(1); rst = 1'b0; oc_flag = '0;
        chk(obs() == normal(4'b0011, 1'b0), "R1 reset leaves latch", obs(), normal(4'b0011, 1'b0));
    endtask

    initial begin
        step(1);
        t_reset();
        t_each_bit();
        t_gap();
        t_retry();
        t_persist();
        t_latch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule